// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This purely combinational unit sits beside the execute stage of a five-stage pipeline. For each ALU operand it works out where the newest value of that operand's source register is. The value can come from the register file, from the ALU result waiting in the execute/memory boundary register, or from the result waiting in the memory/writeback boundary register. For each operand it gives one 2-bit code that steers that operand's multiplexer.

Register 31 always reads as zero. A result written to register 31 is therefore never bypassed, whichever stage holds it. When both later stages write the same register that an operand reads, the younger result wins; that is the one in the execute/memory stage. Operand B's selected value may later be replaced by an immediate, but that multiplexer is outside this unit, and so are load-use stalls.

The style favours state machines, but this unit has no state. It has no states or transitions: every output follows its inputs within the same cycle.

Top module: `bypass_select`

## Requirements
- R1: When no stage qualifies as a bypass source for an operand, that operand's code is 2'b00, which selects the register file value.
- R2: When the execute/memory stage has its write enable high, its destination is not 31, and its destination equals the operand's source, the code is 2'b10.
- R3: When the memory/writeback stage has its write enable high, its destination is not 31, and its destination equals the operand's source, and R2 does not apply to that operand, the code is 2'b01.
- R4: When R2 and R3 both hold for the same operand, the code is 2'b10, so the younger execute/memory result wins.
- R5: An execute/memory destination of 31 never causes a bypass, even when the source is 31. It also does not block a bypass from memory/writeback.
- R6: A memory/writeback destination of 31 never causes a bypass, even when the source is 31.
- R7: A stage whose write enable is low is never selected, and it does not block the other stage.
- R8: Operand A is compared with `src_a` and drives `sel_a`. Operand B is compared with `src_b` and drives `sel_b`. The two operands are resolved independently, so both can be bypassed in the same cycle from the same stage or from different stages.
- R9: The code 2'b11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 5 | Source register number of operand A |
| src_b | input | 5 | Source register number of operand B |
| exm_we | input | 1 | Write enable held in the execute/memory stage |
| exm_dst | input | 5 | Destination register held in the execute/memory stage |
| mwb_we | input | 1 | Write enable held in the memory/writeback stage |
| mwb_dst | input | 5 | Destination register held in the memory/writeback stage |
| sel_a | output | 2 | Operand A source code (00 register file, 01 memory/writeback, 10 execute/memory) |
| sel_b | output | 2 | Operand B source code, same encoding |

## Verification
The hardest case to reach is one where the priority and the zero-register exclusion interact. An example is both stages naming register 31 while an operand reads 31, where a wrong blocking term would still give a plausible 00. Another is an execute/memory entry that matches the source but has its enable low or its destination at 31, which must not suppress a valid memory/writeback bypass. The directed tasks set up these overlaps on purpose. They also drive double hazards on both operands at once, with A and B resolved from different stages. A sweep over every source number then checks each code against an independent model.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
    localparam int REG_W    = 5;
    localparam int ZERO_REG = 31;

    typedef enum logic [1:0] {
        PICK_RF  = 2'b00,
        PICK_MWB = 2'b01,
        PICK_EXM = 2'b10
    } pick_e;
endpackage

// File: rtl/bypass_match.sv
module bypass_match #(
    parameter int REG_W    = 5,
    parameter int ZERO_REG = 31
) (
    input  logic             wr_en,
    input  logic [REG_W-1:0] dst,
    input  logic [REG_W-1:0] src,
    output logic             hit
);
    localparam logic [REG_W-1:0] ZR = REG_W'(ZERO_REG);

    always_comb begin
        hit = wr_en && (dst != ZR) && (dst == src);
    end
endmodule

// File: rtl/bypass_pick.sv
module bypass_pick
    import bypass_pkg::*;
(
    input  logic  exm_hit,
    input  logic  mwb_hit,
    output pick_e pick
);
    always_comb begin
        unique case ({exm_hit, mwb_hit})
            2'b10, 2'b11: pick = PICK_EXM;
            2'b01:        pick = PICK_MWB;
            default:      pick = PICK_RF;
        endcase
    end
endmodule

// File: rtl/bypass_select.sv
module bypass_select
    import bypass_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int ZR = ZERO_REG
) (
    input  logic [RW-1:0] src_a,
    input  logic [RW-1:0] src_b,
    input  logic          exm_we,
    input  logic [RW-1:0] exm_dst,
    input  logic          mwb_we,
    input  logic [RW-1:0] mwb_dst,
    output logic [1:0]    sel_a,
    output logic [1:0]    sel_b
);
    localparam int N_OPS = 2;

    logic [RW-1:0] srcs  [N_OPS];
    logic [1:0]    picks [N_OPS];

    assign srcs[0] = src_a;
    assign srcs[1] = src_b;

    for (genvar op = 0; op < N_OPS; op++) begin : g_op
        logic  exm_hit;
        logic  mwb_hit;
        pick_e pick;

        bypass_match #(.REG_W(RW), .ZERO_REG(ZR)) u_exm (
            .wr_en (exm_we),
            .dst   (exm_dst),
            .src   (srcs[op]),
            .hit   (exm_hit)
        );

        bypass_match #(.REG_W(RW), .ZERO_REG(ZR)) u_mwb (
            .wr_en (mwb_we),
            .dst   (mwb_dst),
            .src   (srcs[op]),
            .hit   (mwb_hit)
        );

        bypass_pick u_pick (
            .exm_hit (exm_hit),
            .mwb_hit (mwb_hit),
            .pick    (pick)
        );

        assign picks[op] = pick;
    end

    assign sel_a = picks[0];
    assign sel_b = picks[1];
endmodule

// File: rtl/bypass_select_chk.sv
module bypass_select_chk #(
    parameter int RW = 5,
    parameter int ZR = 31
) (
    input logic [RW-1:0] src_a,
    input logic [RW-1:0] src_b,
    input logic          exm_we,
    input logic [RW-1:0] exm_dst,
    input logic          mwb_we,
    input logic [RW-1:0] mwb_dst,
    input logic [1:0]    sel_a,
    input logic [1:0]    sel_b
);
    localparam logic [RW-1:0] Z = RW'(ZR);

    always_comb begin
        // R2
        exm_a_src_chk: assert (sel_a != 2'b10 || (exm_we && exm_dst != Z && exm_dst == src_a));
        // R2
        exm_b_src_chk: assert (sel_b != 2'b10 || (exm_we && exm_dst != Z && exm_dst == src_b));
        // R3
        mwb_a_src_chk: assert (sel_a != 2'b01 || (mwb_we && mwb_dst != Z && mwb_dst == src_a));
        // R3
        mwb_b_src_chk: assert (sel_b != 2'b01 || (mwb_we && mwb_dst != Z && mwb_dst == src_b));
        // R4
        young_a_chk: assert (sel_a != 2'b01 || !(exm_we && exm_dst != Z && exm_dst == src_a));
        // R4
        young_b_chk: assert (sel_b != 2'b01 || !(exm_we && exm_dst != Z && exm_dst == src_b));
        // R9
        no_code3_chk: assert (sel_a != 2'b11 && sel_b != 2'b11);
        // R5
        zero_src_chk: assert (src_a != Z || sel_a == 2'b00);
    end
endmodule

bind bypass_select bypass_select_chk #(.RW(RW), .ZR(ZR)) u_chk (.*);

// File: tb/test_bypass_select.sv
module test_bypass_select;
    logic       clk = 0;
    logic       rst = 1;
    logic [4:0] src_a, src_b, exm_dst, mwb_dst;
    logic       exm_we, mwb_we;
    logic [1:0] sel_a, sel_b;
    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bypass_select i_bypass_select (.*);

    function automatic logic [1:0] model(input logic [4:0] s, input logic ew,
                                         input logic [4:0] ed, input logic mw,
                                         input logic [4:0] md);
        if (ew && ed != 5'd31 && ed == s) return 2'b10;
        if (mw && md != 5'd31 && md == s) return 2'b01;
        return 2'b00;
    endfunction

    task automatic drive(input logic [4:0] a, input logic [4:0] b, input logic ew,
                         input logic [4:0] ed, input logic mw, input logic [4:0] md);
        @(negedge clk);
        src_a = a; src_b = b; exm_we = ew; exm_dst = ed; mwb_we = mw; mwb_dst = md;
        #2;
    endtask

    task automatic check(input string req, input logic [1:0] ea, input logic [1:0] eb);
        compared++;
        if (sel_a !== ea || sel_b !== eb) begin
            mismatched++;
            $display("FAIL %s: sel_a=%b sel_b=%b expected %b %b", req, sel_a, sel_b, ea, eb);
        end
    endtask

    task automatic t_idle;
        drive(5'd1, 5'd2, 1'b0, 5'd1, 1'b0, 5'd2);
        check("R1 R7 disabled stages", 2'b00, 2'b00);
        drive(5'd3, 5'd4, 1'b1, 5'd7, 1'b1, 5'd8);
        check("R1 no match", 2'b00, 2'b00);
    endtask

    task automatic t_single;
        drive(5'd3, 5'd4, 1'b1, 5'd3, 1'b0, 5'd0);
        check("R2 exm on A", 2'b10, 2'b00);
        drive(5'd3, 5'd4, 1'b0, 5'd0, 1'b1, 5'd4);
        check("R3 mwb on B", 2'b00, 2'b01);
    endtask

    task automatic t_priority;
        drive(5'd6, 5'd9, 1'b1, 5'd6, 1'b1, 5'd6);
        check("R4 both stages on A", 2'b10, 2'b00);
        drive(5'd6, 5'd6, 1'b0, 5'd6, 1'b1, 5'd6);
        check("R7 exm disabled does not block", 2'b01, 2'b01);
    endtask

    task automatic t_zero;
        drive(5'd31, 5'd31, 1'b1, 5'd31, 1'b0, 5'd0);
        check("R5 exm dst 31", 2'b00, 2'b00);
        drive(5'd31, 5'd31, 1'b0, 5'd0, 1'b1, 5'd31);
        check("R6 mwb dst 31", 2'b00, 2'b00);
        drive(5'd31, 5'd31, 1'b1, 5'd31, 1'b1, 5'd31);
        check("R5 R6 both dst 31", 2'b00, 2'b00);
        drive(5'd12, 5'd31, 1'b1, 5'd31, 1'b1, 5'd12);
        check("R5 exm 31 does not block", 2'b01, 2'b00);
    endtask

    task automatic t_double;
        drive(5'd10, 5'd11, 1'b1, 5'd10, 1'b1, 5'd11);
        check("R8 A from exm, B from mwb", 2'b10, 2'b01);
        drive(5'd13, 5'd13, 1'b1, 5'd13, 1'b1, 5'd13);
        check("R8 R4 both operands same reg", 2'b10, 2'b10);
        drive(5'd0, 5'd0, 1'b1, 5'd0, 1'b0, 5'd0);
        check("R8 R2 register zero is ordinary", 2'b10, 2'b10);
    endtask

    task automatic t_sweep;
        for (int s = 0; s < 32; s++) begin
            drive(5'(s), 5'(31 - s), 1'b1, 5'd9, 1'b1, 5'd22);
            check("R9 R8 sweep",
                  model(5'(s), 1'b1, 5'd9, 1'b1, 5'd22),
                  model(5'(31 - s), 1'b1, 5'd9, 1'b1, 5'd22));
        end
    endtask

    initial begin
        src_a = 0; src_b = 0; exm_we = 0; exm_dst = 0; mwb_we = 0; mwb_dst = 0;
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk); #2;
        check("R1 reset state", 2'b00, 2'b00);
        t_idle();
        t_single();
        t_priority();
        t_zero();
        t_double();
        t_sweep();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule